// File: doc/BRIEF.md
# Multiply-Step Unit

This block performs a single iteration of a shift-and-add multiplication each time its step strobe is raised. It keeps a 32-bit multiplier shift register (Y) and an 8-bit condition-flag register. On every step, the incoming accumulator is shifted right by one. The vacated top bit is filled from the sign recovered out of the previous flags, which is negative XOR overflow. The multiplicand is then added if the current low bit of Y is set. The bit dropped from the accumulator moves into the top of Y.

A controller first loads the multiplier into Y and clears the flags. It then issues 32 steps with the multiplicand, feeding the registered result back as the accumulator each time. A final step with a zero multiplicand follows. At the end, the low word of the result holds the high half of the product and Y holds the low half. Correcting the product for a negative multiplier is left to the caller.

Top module: `mstep_unit`

## Requirements
- R1: After a synchronous reset, `res_o`, `y_o` and `cc_o` are all zero.
- R2: When `ld_i` is high at a clock edge, Y takes `y_ld_i` and the flags take `cc_ld_i`, and `res_o` keeps its value. This holds even when `step_i` is also high, because the load has priority and the step in that cycle is dropped.
- R3: When neither `ld_i` nor `step_i` is high, `res_o`, `y_o` and `cc_o` hold their values whatever the operand inputs do.
- R4: The shifted accumulator used by a step is `{cc[3] ^ cc[1], op1_i[31:1]}`, taken from the flags as they were before the step (bit 3 is the 32-bit negative flag, bit 1 is the 32-bit overflow flag).
- R5: The addend is `op2_i[31:0]` when `y_o[0]` is 1 before the step, and zero otherwise.
- R6: After a step, `res_o[31:0]` is the 32-bit sum of the shifted accumulator and the addend, and `res_o[63:32]` copies `res_o[31]`.
- R7: After a step, `y_o` is `{old op1_i[0], old y_o[31:1]}`.
- R8: The 32-bit flags after a step are bit 0 = carry out of bit 31, bit 1 = signed overflow of the 32-bit add, bit 2 = low word zero, bit 3 = bit 31 of the sum.
- R9: The 64-bit flags are bit 4 = carry out of bit 63, bit 5 = signed overflow at bit 63, bit 6 = whole result zero, bit 7 = bit 63 of the result. For bits 4 and 5, both addend terms and the result are taken sign-extended from 32 bits.
- R10: The following sequence leaves `{res_o[31:0], y_o}` equal to the signed multiplicand times the unsigned multiplier, as a 64-bit two's-complement value: load Y with the multiplier and the flags with zero, then run 32 steps with the multiplicand in `op2_i` and `op1_i` = 0 first and then the previous `res_o`, then run one step with `op2_i` = 0.
- R11: Bits 63:32 of `op1_i` and `op2_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Perform one multiply step at this edge |
| ld_i | input | 1 | Load Y and flags at this edge (wins over step) |
| op1_i | input | 64 | Incoming accumulator (low 32 bits used) |
| op2_i | input | 64 | Multiplicand (low 32 bits used) |
| y_ld_i | input | 32 | Value loaded into Y |
| cc_ld_i | input | 8 | Value loaded into the flags |
| res_o | output | 64 | Registered step result, sign-extended from bit 31 |
| y_o | output | 32 | Multiplier shift register |
| cc_o | output | 8 | Condition flags |

## Verification
The hardest state to reach from the ports is a step whose fill bit comes from a negative flag and an overflow flag that disagree. That same step must also raise both the 32-bit carry and overflow and produce a zero word. A mid-sequence step seldom lines these up. The bench therefore forces the flag register through the load port, picks Y with bit 0 set, and chooses operands whose sum wraps exactly to zero. Full 33-step products with extreme multiplicands (most negative, most positive, all-ones multiplier) then exercise the fill-bit path under sign changes that arise naturally.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    localparam int unsigned MS_DW = 32;
    localparam int unsigned MS_XW = 2 * MS_DW;

    // Flag register layout, most significant first: 64-bit group then 32-bit group.
    typedef struct packed {
        logic xn;
        logic xz;
        logic xv;
        logic xc;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam int unsigned MS_CCW = $bits(ccr_t);

    // Carry out of a bit position from the two operand bits and the result bit.
    function automatic logic carry_from(input logic a, input logic b, input logic r);
        return (a & b) | (~r & (a | b));
    endfunction

    // Signed overflow from the operand sign bits and the result sign bit.
    function automatic logic ovf_from(input logic a, input logic b, input logic r);
        return (a == b) && (r != a);
    endfunction

endpackage

// File: rtl/mstep_prep.sv
module mstep_prep #(
    parameter int unsigned DW = mstep_pkg::MS_DW
) (
    input  logic [DW-1:0] op1_i,
    input  logic [DW-1:0] op2_i,
    input  logic          y_lsb_i,
    input  logic          fill_i,
    output logic [DW-1:0] pp_o,
    output logic [DW-1:0] addend_o,
    output logic          drop_o
);

    // Shift the accumulator down; the recovered sign refills the top bit.
    always_comb begin
        pp_o     = {fill_i, op1_i[DW-1:1]};
        addend_o = y_lsb_i ? op2_i : '0;
        drop_o   = op1_i[0];
    end

endmodule

// File: rtl/mstep_adder.sv
module mstep_adder
    import mstep_pkg::*;
#(
    parameter int unsigned DW = MS_DW,
    localparam int unsigned XW = 2 * DW
) (
    input  logic [DW-1:0] pp_i,
    input  logic [DW-1:0] addend_i,
    output logic [XW-1:0] res_o,
    output ccr_t          cc_o
);

    logic [DW:0]   sum_w;
    logic [DW-1:0] low_w;
    logic          sa, sb, sr;

    always_comb begin
        sum_w = {1'b0, pp_i} + {1'b0, addend_i};
        low_w = sum_w[DW-1:0];
        res_o = {{DW{low_w[DW-1]}}, low_w};

        sa = pp_i[DW-1];
        sb = addend_i[DW-1];
        sr = low_w[DW-1];

        cc_o.c  = sum_w[DW];
        cc_o.v  = ovf_from(sa, sb, sr);
        cc_o.z  = (low_w == '0);
        cc_o.n  = sr;

        // Wide view: operands and result sign-extended, so only their top bits matter.
        cc_o.xc = carry_from(sa, sb, res_o[XW-1]);
        cc_o.xv = ovf_from(sa, sb, res_o[XW-1]);
        cc_o.xz = (res_o == '0);
        cc_o.xn = res_o[XW-1];
    end

endmodule

// File: rtl/mstep_state.sv
module mstep_state
    import mstep_pkg::*;
#(
    parameter int unsigned DW = MS_DW,
    localparam int unsigned XW = 2 * DW
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          step_i,
    input  logic          ld_i,
    input  logic [DW-1:0] y_ld_i,
    input  ccr_t          cc_ld_i,
    input  logic [DW-1:0] y_nxt_i,
    input  ccr_t          cc_nxt_i,
    input  logic [XW-1:0] res_nxt_i,
    output logic [DW-1:0] y_q_o,
    output ccr_t          cc_q_o,
    output logic [XW-1:0] res_q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            y_q_o   <= '0;
            cc_q_o  <= '0;
            res_q_o <= '0;
        end else if (ld_i) begin
            y_q_o  <= y_ld_i;
            cc_q_o <= cc_ld_i;
        end else if (step_i) begin
            y_q_o   <= y_nxt_i;
            cc_q_o  <= cc_nxt_i;
            res_q_o <= res_nxt_i;
        end
    end

    // R3: with no strobe nothing moves.
    p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ld_i && !step_i) |=> ($stable(y_q_o) && $stable(cc_q_o) && $stable(res_q_o)));

    // R2: a load takes the load ports and leaves the result alone.
    p_load_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ld_i |=> ((y_q_o == $past(y_ld_i)) && (cc_q_o == $past(cc_ld_i)) && $stable(res_q_o)));

endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
    import mstep_pkg::*;
#(
    parameter int unsigned DW = MS_DW,
    localparam int unsigned XW = 2 * DW
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          step_i,
    input  logic          ld_i,
    input  logic [XW-1:0] op1_i,
    input  logic [XW-1:0] op2_i,
    input  logic [DW-1:0] y_ld_i,
    input  logic [7:0]    cc_ld_i,
    output logic [XW-1:0] res_o,
    output logic [DW-1:0] y_o,
    output logic [7:0]    cc_o
);

    ccr_t          cc_q;
    ccr_t          cc_nxt;
    logic [DW-1:0] y_q;
    logic [DW-1:0] y_nxt;
    logic [XW-1:0] res_q;
    logic [XW-1:0] res_nxt;
    logic [DW-1:0] pp;
    logic [DW-1:0] addend;
    logic          drop;
    logic          fill;

    // Upper operand halves are deliberately ignored.
    logic          unused_hi_bits;
    assign unused_hi_bits = ^{op1_i[XW-1:DW], op2_i[XW-1:DW]};

    assign fill = cc_q.n ^ cc_q.v;

    mstep_prep #(.DW(DW)) prep_i (
        .op1_i    (op1_i[DW-1:0]),
        .op2_i    (op2_i[DW-1:0]),
        .y_lsb_i  (y_q[0]),
        .fill_i   (fill),
        .pp_o     (pp),
        .addend_o (addend),
        .drop_o   (drop)
    );

    mstep_adder #(.DW(DW)) add_i (
        .pp_i     (pp),
        .addend_i (addend),
        .res_o    (res_nxt),
        .cc_o     (cc_nxt)
    );

    assign y_nxt = {drop, y_q[DW-1:1]};

    mstep_state #(.DW(DW)) state_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .step_i    (step_i),
        .ld_i      (ld_i),
        .y_ld_i    (y_ld_i),
        .cc_ld_i   (ccr_t'(cc_ld_i)),
        .y_nxt_i   (y_nxt),
        .cc_nxt_i  (cc_nxt),
        .res_nxt_i (res_nxt),
        .y_q_o     (y_q),
        .cc_q_o    (cc_q),
        .res_q_o   (res_q)
    );

    assign res_o = res_q;
    assign y_o   = y_q;
    assign cc_o  = cc_q;

    // R6: upper half of the result always mirrors bit DW-1.
    p_sext_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        res_o[XW-1:DW] == {DW{res_o[DW-1]}});

    // R7: Y shifts down and receives the accumulator's dropped bit.
    p_yshift_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !ld_i) |=> (y_o == {$past(op1_i[0]), $past(y_o[DW-1:1])}));

    // R5: with Y bit 0 clear, the result is just the shifted accumulator.
    p_noadd_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !ld_i && !y_o[0]) |=> (res_o[DW-2:0] == $past(op1_i[DW-1:1])));

    // R9: with sign-extended terms the wide flags track the narrow ones.
    p_wideflags_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (cc_nxt.xv == cc_nxt.v) && (cc_nxt.xn == cc_nxt.n) && (cc_nxt.xz == cc_nxt.z));

endmodule

// File: tb/mstep_unit_tb_top.sv
module mstep_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_s = 1'b0;
    logic        ld_s = 1'b0;
    logic        probe_s = 1'b0;
    logic [63:0] op1_s = '0;
    logic [63:0] op2_s = '0;
    logic [31:0] y_ld_s = '0;
    logic [7:0]  cc_ld_s = '0;
    logic [63:0] res_w;
    logic [31:0] y_w;
    logic [7:0]  cc_w;

    int checks = 0;
    int errors = 0;

    // Scoreboard queues.
    logic [63:0] q_res[$];
    logic [31:0] q_y[$];
    logic [7:0]  q_cc[$];
    string       q_tag[$];

    // Reference model state.
    logic [63:0] m_res = '0;
    logic [31:0] m_y = '0;
    logic [7:0]  m_cc = '0;

    logic pend = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mstep_unit dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .step_i  (step_s),
        .ld_i    (ld_s),
        .op1_i   (op1_s),
        .op2_i   (op2_s),
        .y_ld_i  (y_ld_s),
        .cc_ld_i (cc_ld_s),
        .res_o   (res_w),
        .y_o     (y_w),
        .cc_o    (cc_w)
    );

    always @(posedge clk) pend <= step_s | ld_s | probe_s;

    // Monitor: compares the oldest expectation after every strobed edge.
    always @(negedge clk) begin
        if (pend) begin
            if (q_tag.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: result with no expectation res=%h", res_w);
            end else begin
                logic [63:0] er;
                logic [31:0] ey;
                logic [7:0]  ec;
                string       t;
                er = q_res.pop_front();
                ey = q_y.pop_front();
                ec = q_cc.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (res_w !== er || y_w !== ey || cc_w !== ec) begin
                    errors++;
                    $display("FAIL %s: res=%h y=%h cc=%h expected res=%h y=%h cc=%h",
                             t, res_w, y_w, cc_w, er, ey, ec);
                end
            end
        end
    end

    task automatic push_exp(input string tag);
        q_res.push_back(m_res);
        q_y.push_back(m_y);
        q_cc.push_back(m_cc);
        q_tag.push_back(tag);
    endtask

    // Reference for one step, written from the requirements.
    task automatic model_step(input logic [63:0] o1, input logic [63:0] o2);
        logic [31:0] pp, ad, lo;
        logic [32:0] s;
        logic [7:0]  nc;
        pp = {m_cc[3] ^ m_cc[1], o1[31:1]};           // R4
        ad = m_y[0] ? o2[31:0] : 32'h0;                // R5
        s  = {1'b0, pp} + {1'b0, ad};
        lo = s[31:0];
        nc[0] = s[32];                                 // R8
        nc[1] = (pp[31] == ad[31]) && (lo[31] != pp[31]);
        nc[2] = (lo == 32'h0);
        nc[3] = lo[31];
        nc[4] = (pp[31] & ad[31]) | (~lo[31] & (pp[31] | ad[31])); // R9
        nc[5] = (pp[31] == ad[31]) && (lo[31] != pp[31]);
        nc[6] = ({{32{lo[31]}}, lo} == 64'h0);
        nc[7] = lo[31];
        m_res = {{32{lo[31]}}, lo};                    // R6
        m_y   = {o1[0], m_y[31:1]};                    // R7
        m_cc  = nc;
    endtask

    task automatic drv_step(input logic [63:0] o1, input logic [63:0] o2, input string tag);
        @(negedge clk);
        op1_s  = o1;
        op2_s  = o2;
        step_s = 1'b1;
        model_step(o1, o2);
        push_exp(tag);
        @(negedge clk);
        step_s = 1'b0;
    endtask

    task automatic drv_load(input logic [31:0] yv, input logic [7:0] ccv, input logic with_step,
                            input logic [63:0] o1, input logic [63:0] o2, input string tag);
        @(negedge clk);
        y_ld_s  = yv;
        cc_ld_s = ccv;
        op1_s   = o1;
        op2_s   = o2;
        ld_s    = 1'b1;
        step_s  = with_step;
        m_y     = yv;
        m_cc    = ccv;
        push_exp(tag);
        @(negedge clk);
        ld_s   = 1'b0;
        step_s = 1'b0;
    endtask

    task automatic drv_probe(input logic [63:0] o1, input logic [63:0] o2, input string tag);
        @(negedge clk);
        op1_s   = o1;
        op2_s   = o2;
        probe_s = 1'b1;
        push_exp(tag);
        @(negedge clk);
        probe_s = 1'b0;
    endtask

    task automatic mul_run(input logic [31:0] mc, input logic [31:0] mp, input string tag);
        logic signed [63:0] prod;
        drv_load(mp, 8'h00, 1'b0, 64'h0, 64'h0, "R10 init load");
        for (int k = 0; k < 32; k++) begin
            drv_step((k == 0) ? 64'h0 : m_res, {32'hC0DE_0000 ^ 32'(k), mc}, "R10 R11 step");
        end
        drv_step(m_res, 64'hFFFF_FFFF_0000_0000, "R10 final step");
        @(negedge clk);
        prod = $signed({{32{mc[31]}}, mc}) * $signed({32'h0, mp});
        checks++;
        if ({res_w[31:0], y_w} !== prod) begin
            errors++;
            $display("FAIL R10 %s: product=%h expected=%h", tag, {res_w[31:0], y_w}, prod);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        drv_probe(64'h0, 64'h0, "R1 reset state");

        drv_load(32'hA5A5_0F0F, 8'h3C, 1'b0, 64'h1, 64'h2, "R2 load");
        drv_probe(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R3 idle hold");
        drv_probe(64'h5555_5555_AAAA_AAAA, 64'h0, "R3 idle hold 2");

        // Y bit 0 clear: no add; op1 bit 0 enters Y.
        drv_load(32'h0000_0002, 8'h00, 1'b0, 64'h0, 64'h0, "R2 load");
        drv_step(64'hFFFF_0000_0000_0003, 64'hFFFF_0000_0000_1234, "R5 R7 R11 no add");

        // Negative without overflow: fill bit is 1.
        drv_load(32'h0000_0001, 8'h08, 1'b0, 64'h0, 64'h0, "R2 load");
        drv_step(64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, "R4 R6 fill one");

        // Negative with overflow: fill bit is 0.
        drv_load(32'h0000_0001, 8'h0A, 1'b0, 64'h0, 64'h0, "R2 load");
        drv_step(64'h0000_0000_FFFF_FFFE, 64'h0000_0000_0000_0010, "R4 fill zero");

        // Wrap to zero with carry and overflow.
        drv_load(32'h0000_0001, 8'h08, 1'b0, 64'h0, 64'h0, "R2 load");
        drv_step(64'h0, 64'h0000_0000_8000_0000, "R8 R9 carry overflow zero");

        // Positive overflow into bit 31.
        drv_load(32'h0000_0001, 8'h00, 1'b0, 64'h0, 64'h0, "R2 load");
        drv_step(64'h0000_0000_7FFF_FFFE, 64'h0000_0000_4000_0001, "R8 R9 positive overflow");

        // Load and step together: load wins, result untouched.
        drv_load(32'hDEAD_BEEF, 8'hF0, 1'b1, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0009,
                 "R2 load beats step");

        mul_run(32'd5, 32'd3, "small");
        mul_run(32'hFFFF_FFF9, 32'hFFFF_FFFF, "negative multiplicand");
        mul_run(32'h7FFF_FFFF, 32'hFFFF_FFFF, "largest positive");
        mul_run(32'h8000_0000, 32'h1234_5678, "most negative");
        mul_run(32'h0, 32'h8765_4321, "zero multiplicand");

        repeat (3) @(negedge clk);
        checks++;
        if (q_tag.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q_tag.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule